// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Channel

This block sequences one channel of a buffer-pool DMA engine that works over two buffers in turn. A source port adapter fills a buffer one 32-bit line at a time. The block generates each line index from a start index, a step and an inclusive last index. When the fill ends, that buffer is handed to the destination port adapter and drained. Meanwhile the source moves on to the other buffer. The buffer RAM and the adapters sit outside. The block supplies only line indices, the buffer select, the port numbers and valid/ready handshakes.

Software sets up the channel by writing three write-only words: a source word, a destination word and a control word. Writing the control word issues a command. Commands start and stop streaming, and reset the channel. Two more command pairs gate each filled buffer in approval mode: one lets the buffer drain, the other discards it. A send pair pushes a buffer that the processor has filled itself out to the destination. A four-bit flag word reports which buffers hold data, whether the channel is busy, and whether a command was refused.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After rst_n is released, or after the reset command, stat_flags is 0, fill_ready is 0 and drain_valid is 0.
- R2: Source and destination words share one layout: bit 31 is zero, bits 30:27 hold the port number, 26:18 the start line, 17:9 the inclusive last line and 8:0 the step. The source word is written with cfg_sel=0 and the destination word with cfg_sel=1. A fill visits start, start+step, and so on. The line just before the sum would pass the last line is the final one, so start equal to last gives a single line.
- R3: A fill beat with fill_eop high ends the fill at once. fill_last_line then holds the final line index written, for both early and normal ends.
- R4: A normal drain sends as many lines as the buffer received. The lines run from the destination start and advance by the destination step, on drain_buf equal to the filled buffer.
- R5: Buffers fill in strict alternation, 0 then 1, and drain in the same order. fill_ready stays low while the next buffer to fill still holds data.
- R6: The control word is written with cfg_sel=2 and carries the command in bits 3:0 and the approval bit in bit 4. Command 1 starts the channel. When it is given with the approval bit set, each filled buffer sets its flag and stays undrained until command 3 (buffer 0) or command 4 (buffer 1) approves it.
- R7: Command 5 (buffer 0) or command 6 (buffer 1) discards a held buffer without draining it. Its flag clears and filling carries on.
- R8: Command 7 (buffer 0) or command 8 (buffer 1) is accepted only while the channel is idle. It drains the named buffer over the lines from the destination start to the destination last line, inclusive.
- R9: Command 2 lets the fill in progress finish and then stops filling. Buffers already filled still drain, after which busy (flag bit 2) clears.
- R10: Command 0 aborts any fill or drain at once and returns the channel to idle.
- R11: Flag bit 3 is a sticky error that only command 0 clears. It is set by codes 9 to 15, by approve or discard without a held buffer, by start or send while busy, by stop while not running, and by start with a nonzero destination last line. Flag bits 0 and 1 show that buffer 0 and buffer 1 hold data.
- R12: While drain_valid is high and drain_ready is low, drain_valid, drain_line and drain_buf hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 2 | Word select: 0 source, 1 destination, 2 control |
| cfg_wdata | input | 32 | Configuration word |
| fill_port | output | 4 | Source port number |
| fill_buf | output | 1 | Buffer being filled |
| fill_line | output | 9 | Line index for the current fill beat |
| fill_ready | output | 1 | Block accepts a source line |
| fill_valid | input | 1 | Source offers a line |
| fill_eop | input | 1 | This source line ends the packet |
| drain_port | output | 4 | Destination port number |
| drain_buf | output | 1 | Buffer being drained |
| drain_line | output | 9 | Line index for the current drain beat |
| drain_valid | output | 1 | Block offers a line to the destination |
| drain_ready | input | 1 | Destination takes the line |
| stat_flags | output | 4 | {error, busy, buffer 1 full, buffer 0 full} |
| fill_last_line | output | 9 | Last line index of the most recent fill |

## Verification
The fill of one buffer and the drain of the other run in the same cycles. The stalled writer shows whether the drain pointer and the fill pointer ever meet. Two collisions are provoked on purpose. In one, a stop command arrives while the final beats of a fill are in flight. The run must then end on that buffer, with no extra fill, while the other buffer keeps draining. In the other, a discard command hits one buffer while the second buffer sits in its approval hold. A scoreboard of expected (buffer, line) pairs on both sides judges each case, and any unexpected beat counts as a failure.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
    localparam int LINE_W_DEF = 9;
    localparam int PORT_W_DEF = 4;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_HOLD  = 2'd1,
        BUF_READY = 2'd2
    } buf_state_e;

    typedef enum logic [3:0] {
        OP_ABORT    = 4'd0,
        OP_RUN      = 4'd1,
        OP_HALT     = 4'd2,
        OP_ACCEPT0  = 4'd3,
        OP_ACCEPT1  = 4'd4,
        OP_DISCARD0 = 4'd5,
        OP_DISCARD1 = 4'd6,
        OP_PUSH0    = 4'd7,
        OP_PUSH1    = 4'd8
    } op_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/dma_op_decode.sv
module dma_op_decode
    import dma_pp_pkg::*;
(
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output logic        op_valid,
    output logic [3:0]  op,
    output logic        op_bad,
    output logic        op_gate
);
    always_comb begin
        op_valid = we && (sel == SEL_CTRL);
        op       = wdata[3:0];
        op_gate  = wdata[4];
        op_bad   = op_valid && (wdata[3:0] > 4'd8);
    end
endmodule

// File: rtl/dma_line_walker.sv
module dma_line_walker #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] start,
    input  logic              adv,
    input  logic [LINE_W-1:0] step,
    input  logic [LINE_W-1:0] last_idx,
    output logic [LINE_W-1:0] line,
    output logic              at_last
);
    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (load)     line_d = start;
        else if (adv) line_d = line_q + step;
        at_last = ({1'b0, line_q} + {1'b0, step}) > {1'b0, last_idx};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign line = line_q;
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
    import dma_pp_pkg::*;
#(
    parameter int LINE_W = LINE_W_DEF,
    parameter int PORT_W = PORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [PORT_W-1:0] fill_port,
    output logic              fill_buf,
    output logic [LINE_W-1:0] fill_line,
    output logic              fill_ready,
    input  logic              fill_valid,
    input  logic              fill_eop,
    output logic [PORT_W-1:0] drain_port,
    output logic              drain_buf,
    output logic [LINE_W-1:0] drain_line,
    output logic              drain_valid,
    input  logic              drain_ready,
    output logic [3:0]        stat_flags,
    output logic [LINE_W-1:0] fill_last_line
);
    localparam int CNT_W  = LINE_W + 1;
    localparam int STEP_L = 0;
    localparam int LAST_L = LINE_W;
    localparam int BEG_L  = 2 * LINE_W;
    localparam int PORT_L = 3 * LINE_W;

    typedef struct packed {
        logic [PORT_W-1:0]      src_port;
        logic [LINE_W-1:0]      src_beg, src_last, src_step;
        logic [PORT_W-1:0]      dst_port;
        logic [LINE_W-1:0]      dst_beg, dst_last, dst_step;
        logic                   run, stopping, gate, err;
        logic                   fill_act, fill_ptr;
        logic [CNT_W-1:0]       fill_cnt;
        buf_state_e [1:0]       bstate;
        logic [1:0][CNT_W-1:0]  bcnt;
        logic                   drain_act, drain_push, drain_sel, drain_ptr;
        logic [CNT_W-1:0]       drain_beats;
        logic [LINE_W-1:0]      last_line;
    } chan_t;

    chan_t st_d, st_q;

    logic       op_valid, op_bad, op_gate;
    logic [3:0] op;
    logic       f_load, f_last, d_load, d_last;
    logic       fill_fire, fill_fin, drain_fire, drain_fin, busy;
    logic [LINE_W-1:0] f_line, d_line;

    dma_op_decode i_dec (
        .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .op_valid(op_valid), .op(op), .op_bad(op_bad), .op_gate(op_gate)
    );

    dma_line_walker #(.LINE_W(LINE_W)) i_fill_walk (
        .clk(clk), .rst_n(rst_n), .load(f_load), .start(st_q.src_beg),
        .adv(fill_fire), .step(st_q.src_step), .last_idx(st_q.src_last),
        .line(f_line), .at_last(f_last)
    );

    dma_line_walker #(.LINE_W(LINE_W)) i_drain_walk (
        .clk(clk), .rst_n(rst_n), .load(d_load), .start(st_q.dst_beg),
        .adv(drain_fire), .step(st_q.dst_step), .last_idx(st_q.dst_last),
        .line(d_line), .at_last(d_last)
    );

    always_comb begin
        st_d   = st_q;
        f_load = 1'b0;
        d_load = 1'b0;
        busy   = st_q.run || st_q.fill_act || st_q.drain_act ||
                 (st_q.bstate[0] != BUF_EMPTY) || (st_q.bstate[1] != BUF_EMPTY);
        fill_fire  = st_q.fill_act && fill_valid;
        fill_fin   = fill_fire && (f_last || fill_eop);
        drain_fire = st_q.drain_act && drain_ready;
        drain_fin  = drain_fire && (st_q.drain_push ? d_last :
                     ((st_q.drain_beats + 1'b1) == st_q.bcnt[st_q.drain_sel]));

        if (cfg_we && cfg_sel == SEL_SRC) begin
            st_d.src_port = cfg_wdata[PORT_L +: PORT_W];
            st_d.src_beg  = cfg_wdata[BEG_L +: LINE_W];
            st_d.src_last = cfg_wdata[LAST_L +: LINE_W];
            st_d.src_step = cfg_wdata[STEP_L +: LINE_W];
        end
        if (cfg_we && cfg_sel == SEL_DST) begin
            st_d.dst_port = cfg_wdata[PORT_L +: PORT_W];
            st_d.dst_beg  = cfg_wdata[BEG_L +: LINE_W];
            st_d.dst_last = cfg_wdata[LAST_L +: LINE_W];
            st_d.dst_step = cfg_wdata[STEP_L +: LINE_W];
        end

        // fill sequencing
        if (fill_fire) st_d.fill_cnt = st_q.fill_cnt + 1'b1;
        if (fill_fin) begin
            st_d.fill_act = 1'b0;
            st_d.bstate[st_q.fill_ptr] = st_q.gate ? BUF_HOLD : BUF_READY;
            st_d.bcnt[st_q.fill_ptr]   = st_q.fill_cnt + 1'b1;
            st_d.last_line = f_line;
            st_d.fill_ptr  = ~st_q.fill_ptr;
        end else if (st_q.run && !st_q.fill_act && !st_q.stopping &&
                     st_q.bstate[st_q.fill_ptr] == BUF_EMPTY) begin
            st_d.fill_act = 1'b1;
            st_d.fill_cnt = '0;
            f_load = 1'b1;
        end
        if (st_q.run && st_q.stopping && !st_q.fill_act) begin
            st_d.run = 1'b0;
            st_d.stopping = 1'b0;
        end

        // drain sequencing
        if (drain_fire) st_d.drain_beats = st_q.drain_beats + 1'b1;
        if (drain_fin) begin
            st_d.drain_act  = 1'b0;
            st_d.drain_push = 1'b0;
            if (!st_q.drain_push) st_d.bstate[st_q.drain_sel] = BUF_EMPTY;
        end else if (!st_q.drain_act && st_q.bstate[st_q.drain_ptr] == BUF_READY) begin
            st_d.drain_act   = 1'b1;
            st_d.drain_sel   = st_q.drain_ptr;
            st_d.drain_beats = '0;
            d_load = 1'b1;
        end
        if (st_q.bstate[st_q.drain_ptr] == BUF_EMPTY)
            st_d.drain_ptr = (st_q.bstate[~st_q.drain_ptr] != BUF_EMPTY) ?
                             ~st_q.drain_ptr : st_q.fill_ptr;

        // host commands take precedence
        if (op_valid) begin
            case (op)
                OP_ABORT: begin
                    st_d.run = 1'b0;       st_d.stopping = 1'b0;
                    st_d.fill_act = 1'b0;  st_d.drain_act = 1'b0;
                    st_d.drain_push = 1'b0; st_d.err = 1'b0;
                    st_d.fill_ptr = 1'b0;  st_d.drain_ptr = 1'b0;
                    st_d.bstate = {BUF_EMPTY, BUF_EMPTY};
                    f_load = 1'b0;         d_load = 1'b0;
                end
                OP_RUN: begin
                    if (busy || st_q.dst_last != '0) st_d.err = 1'b1;
                    else begin
                        st_d.run = 1'b1;  st_d.stopping = 1'b0;
                        st_d.gate = op_gate;
                        st_d.fill_ptr = 1'b0; st_d.drain_ptr = 1'b0;
                    end
                end
                OP_HALT: begin
                    if (!st_q.run) st_d.err = 1'b1;
                    else           st_d.stopping = 1'b1;
                end
                OP_ACCEPT0, OP_ACCEPT1: begin
                    if (st_q.bstate[op == OP_ACCEPT1] == BUF_HOLD)
                        st_d.bstate[op == OP_ACCEPT1] = BUF_READY;
                    else st_d.err = 1'b1;
                end
                OP_DISCARD0, OP_DISCARD1: begin
                    if (st_q.bstate[op == OP_DISCARD1] == BUF_HOLD)
                        st_d.bstate[op == OP_DISCARD1] = BUF_EMPTY;
                    else st_d.err = 1'b1;
                end
                OP_PUSH0, OP_PUSH1: begin
                    if (busy) st_d.err = 1'b1;
                    else begin
                        st_d.drain_act   = 1'b1;
                        st_d.drain_push  = 1'b1;
                        st_d.drain_sel   = (op == OP_PUSH1);
                        st_d.drain_beats = '0;
                        d_load = 1'b1;
                    end
                end
                default: st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fill_port      = st_q.src_port;
    assign fill_buf       = st_q.fill_ptr;
    assign fill_line      = f_line;
    assign fill_ready     = st_q.fill_act;
    assign drain_port     = st_q.dst_port;
    assign drain_buf      = st_q.drain_sel;
    assign drain_line     = d_line;
    assign drain_valid    = st_q.drain_act;
    assign fill_last_line = st_q.last_line;
    assign stat_flags     = {st_q.err, busy, st_q.bstate[1] != BUF_EMPTY,
                             st_q.bstate[0] != BUF_EMPTY};

    // R5
    fill_drain_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ready && drain_valid) |-> (fill_buf != drain_buf));

    // R5
    fill_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ready |-> !stat_flags[fill_buf]);

    // R3
    eop_ends_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ready && fill_valid && fill_eop) |=> !fill_ready);

    // R12
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready && !(cfg_we && cfg_sel == SEL_CTRL))
        |=> (drain_valid && $stable(drain_line) && $stable(drain_buf)));

    // R11
    bad_op_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_bad |=> stat_flags[3]);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ABORT) |=> (!fill_ready && !drain_valid && stat_flags == 4'd0));
endmodule

// File: tb/test_pingpong_dma_chan.sv
`timescale 1ns/100ps
module test_pingpong_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  fill_port, drain_port;
    logic        fill_buf, fill_ready, drain_buf, drain_valid;
    logic [8:0]  fill_line, drain_line, fill_last_line;
    logic        fill_valid = 1'b0, fill_eop = 1'b0, drain_ready = 1'b1;
    logic [3:0]  stat_flags;

    int checks = 0;
    int failures = 0;
    logic [9:0] exp_fill[$];
    logic [9:0] exp_drain[$];

    always #2.5 clk = ~clk;

    pingpong_dma_chan i_pingpong_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fill_port(fill_port), .fill_buf(fill_buf),
        .fill_line(fill_line), .fill_ready(fill_ready), .fill_valid(fill_valid),
        .fill_eop(fill_eop), .drain_port(drain_port), .drain_buf(drain_buf),
        .drain_line(drain_line), .drain_valid(drain_valid),
        .drain_ready(drain_ready), .stat_flags(stat_flags),
        .fill_last_line(fill_last_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int port, input int beg, input int last, input int step);
        return {1'b0, 4'(port), 9'(beg), 9'(last), 9'(step)};
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cmd(input int code, input bit gate);
        cfg(2'd2, {27'd0, gate, 4'(code)});
    endtask

    task automatic push_lines(input bit drain, input bit b, input int beg, input int step, input int n);
        for (int k = 0; k < n; k++) begin
            if (drain) exp_drain.push_back({b, 9'(beg + k * step)});
            else       exp_fill.push_back({b, 9'(beg + k * step)});
        end
    endtask

    task automatic feed(input int n, input int eop_at);
        int guard = 0;
        for (int k = 0; k < n && guard < 2000; guard++) begin
            fill_valid = 1'b1;
            fill_eop   = (k == eop_at);
            @(negedge clk);
            if (fill_ready) k++;
            @(posedge clk); #1;
        end
        fill_valid = 1'b0;
        fill_eop   = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int guard = 0;
        while (stat_flags[2] && guard < 3000) begin
            @(posedge clk); #1;
            guard++;
        end
        @(negedge clk);
        chk(!stat_flags[2], req, stat_flags, 0);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fill_ready && fill_valid) begin
                if (exp_fill.size() == 0)
                    chk(1'b0, "R5 unexpected fill beat", {fill_buf, fill_line}, 0);
                else begin
                    logic [9:0] e;
                    e = exp_fill.pop_front();
                    chk({fill_buf, fill_line} == e, "R2 fill beat", {fill_buf, fill_line}, e);
                end
            end
            if (drain_valid && drain_ready) begin
                if (exp_drain.size() == 0)
                    chk(1'b0, "R6 unexpected drain beat", {drain_buf, drain_line}, 0);
                else begin
                    logic [9:0] e;
                    e = exp_drain.pop_front();
                    chk({drain_buf, drain_line} == e, "R4 drain beat", {drain_buf, drain_line}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(stat_flags == 4'd0, "R1 flags", stat_flags, 0);
        chk(!fill_ready && !drain_valid, "R1 handshakes", {fill_ready, drain_valid}, 0);

        // R2/R4/R9: two buffers, stop while buffer 1 fills
        cfg(2'd0, word(2, 2, 4, 1));
        cfg(2'd1, word(1, 10, 0, 1));
        push_lines(0, 0, 2, 1, 3); push_lines(0, 1, 2, 1, 3);
        push_lines(1, 0, 10, 1, 3); push_lines(1, 1, 10, 1, 3);
        cmd(1, 0);
        feed(3, -1);
        feed(1, -1);
        cmd(2, 0);
        @(negedge clk);
        chk(fill_port == 4'd2 && drain_port == 4'd1, "R2 port fields", {fill_port, drain_port}, 8'h21);
        feed(2, -1);
        wait_idle("R9 idle after stop");
        idle_cycles(5);
        @(negedge clk);
        chk(!fill_ready, "R9 no fill after stop", fill_ready, 0);
        chk(exp_fill.size() == 0 && exp_drain.size() == 0, "R9 all beats seen",
            exp_fill.size() + exp_drain.size(), 0);

        // R2 step 2 with last line overshoot, R4 destination step 3
        cfg(2'd0, word(3, 0, 5, 2));
        cfg(2'd1, word(4, 0, 0, 3));
        push_lines(0, 0, 0, 2, 3); push_lines(1, 0, 0, 3, 3);
        cmd(1, 0);
        cmd(2, 0);
        feed(3, -1);
        wait_idle("R2 stepped fill");
        chk(exp_fill.size() == 0 && exp_drain.size() == 0, "R4 stepped drain complete",
            exp_fill.size() + exp_drain.size(), 0);

        // R2 start equals last gives one line
        cfg(2'd0, word(3, 7, 7, 1));
        push_lines(0, 0, 7, 1, 1); push_lines(1, 0, 0, 3, 1);
        cmd(1, 0);
        cmd(2, 0);
        feed(1, -1);
        wait_idle("R2 single line");
        chk(fill_last_line == 9'd7, "R3 last line normal end", fill_last_line, 7);

        // R3 early end of packet
        cfg(2'd0, word(3, 0, 8, 1));
        cfg(2'd1, word(4, 20, 0, 1));
        push_lines(0, 0, 0, 1, 3); push_lines(1, 0, 20, 1, 3);
        cmd(1, 0);
        cmd(2, 0);
        feed(3, 2);
        wait_idle("R3 eop fill");
        chk(fill_last_line == 9'd2, "R3 last line on eop", fill_last_line, 2);
        chk(exp_drain.size() == 0, "R4 drain count after eop", exp_drain.size(), 0);

        // R6/R7 approval gate with a discard while the other buffer is held
        cfg(2'd0, word(3, 0, 1, 1));
        cfg(2'd1, word(4, 0, 0, 1));
        push_lines(0, 0, 0, 1, 2); push_lines(0, 1, 0, 1, 2);
        cmd(1, 1);
        feed(2, -1);
        idle_cycles(6);
        @(negedge clk);
        chk(stat_flags[0] && !drain_valid, "R6 buffer 0 held", {stat_flags[0], drain_valid}, 2);
        feed(2, -1);
        idle_cycles(4);
        @(negedge clk);
        chk(stat_flags == 4'b0111, "R6 both held", stat_flags, 7);
        chk(!fill_ready, "R5 stall while both held", fill_ready, 0);
        cmd(6, 0);
        @(negedge clk);
        chk(stat_flags == 4'b0101, "R7 discard buffer 1", stat_flags, 5);
        push_lines(1, 0, 0, 1, 2);
        push_lines(0, 0, 0, 1, 2);
        cmd(3, 0);
        idle_cycles(8);
        @(negedge clk);
        chk(exp_drain.size() == 0 && fill_ready && fill_buf == 1'b0, "R7 fill resumes on buffer 0",
            {exp_drain.size() == 0, fill_ready, fill_buf}, 6);
        cmd(2, 0);
        feed(2, -1);
        idle_cycles(4);
        @(negedge clk);
        chk(stat_flags == 4'b0101, "R6 held after stop", stat_flags, 5);
        cmd(5, 0);
        wait_idle("R7 discard buffer 0");
        chk(stat_flags == 4'd0, "R7 flags clear", stat_flags, 0);

        // R11 errors
        cmd(3, 0);
        @(negedge clk);
        chk(stat_flags[3], "R11 approve without held buffer", stat_flags, 8);
        cmd(0, 0);
        @(negedge clk);
        chk(stat_flags == 4'd0, "R1 reset command clears error", stat_flags, 0);
        cmd(12, 0);
        @(negedge clk);
        chk(stat_flags[3], "R11 illegal code", stat_flags, 8);
        cmd(0, 0);
        cmd(2, 0);
        @(negedge clk);
        chk(stat_flags[3], "R11 stop while not running", stat_flags, 8);
        cmd(0, 0);
        cfg(2'd1, word(4, 5, 7, 1));
        cmd(1, 0);
        @(negedge clk);
        chk(stat_flags == 4'b1000, "R11 start with nonzero destination last", stat_flags, 8);
        cmd(0, 0);

        // R8 send buffer 1
        push_lines(1, 1, 5, 1, 3);
        cmd(8, 0);
        wait_idle("R8 send done");
        chk(exp_drain.size() == 0, "R8 send lines", exp_drain.size(), 0);

        // R11 start while busy, then R10 abort mid-fill
        cfg(2'd1, word(4, 0, 0, 1));
        cfg(2'd0, word(3, 0, 5, 1));
        push_lines(0, 0, 0, 1, 2);
        cmd(1, 0);
        feed(2, -1);
        cmd(1, 0);
        @(negedge clk);
        chk(stat_flags[3] && stat_flags[2], "R11 start while busy", stat_flags, 12);
        cmd(0, 0);
        @(negedge clk);
        chk(stat_flags == 4'd0 && !fill_ready && !drain_valid, "R10 abort",
            {stat_flags, fill_ready, drain_valid}, 0);

        // R5/R12 stalled writer with a blocked destination
        cfg(2'd0, word(3, 0, 0, 1));
        drain_ready = 1'b0;
        push_lines(0, 0, 0, 1, 1); push_lines(0, 1, 0, 1, 1);
        push_lines(1, 0, 0, 1, 1); push_lines(1, 1, 0, 1, 1);
        cmd(1, 0);
        feed(1, -1);
        feed(1, -1);
        idle_cycles(3);
        @(negedge clk);
        begin
            logic [8:0] hold_line;
            hold_line = drain_line;
            chk(drain_valid && drain_buf == 1'b0, "R12 drain offered", {drain_valid, drain_buf}, 2);
            chk(!fill_ready && stat_flags[1:0] == 2'b11, "R5 writer stalled",
                {fill_ready, stat_flags[1:0]}, 3);
            idle_cycles(6);
            @(negedge clk);
            chk(drain_valid && drain_line == hold_line && drain_buf == 1'b0, "R12 drain held",
                {drain_valid, drain_buf, drain_line}, {1'b1, 1'b0, hold_line});
            chk(!fill_ready, "R5 still stalled", fill_ready, 0);
        end
        cmd(2, 0);
        @(posedge clk); #1;
        drain_ready = 1'b1;
        wait_idle("R9 drain after stop");
        chk(exp_fill.size() == 0 && exp_drain.size() == 0, "R5 alternation complete",
            exp_fill.size() + exp_drain.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule